// File: doc/BRIEF.md
# Settled DAC Conversion Sequencer

This block is the digital side of one digital-to-analog converter channel, attached to a chip's APB register bus. Software stores a sample word in a holding register. When a conversion begins, the block extracts a 12-bit code from that word and latches it into an output register that drives the analog core. It also raises a one-cycle start strobe toward the analog core.

A programmable settling count, measured in bus-clock cycles, sets how long the conversion stays busy. After that count the block raises a completion flag. A conversion starts in one of two ways. In direct mode, a write to the holding register starts it. In trigger mode, a qualified trigger input or a self-clearing software trigger bit starts it.

When DMA mode is enabled, a trigger that finds no fresh sample sets an under-run flag. Both status flags are cleared by writing 1 to them. Each flag can be masked into a single interrupt line.

Top module: `dac_seq_top`

## Requirements
- R1: A bus write takes effect when `psel`, `penable` and `pwrite` are all high. The register word offsets are: control 0x00, software trigger 0x04, holding 0x08, output 0x0C, status 0x10, settling 0x14. The control bits are: 0 run enable, 1 finish interrupt enable, 2 DMA mode, 3 under-run interrupt enable, 4 trigger mode, 10 left alignment, [15:14] width code. Control reads back only those bits. Holding reads back bits [15:0]. Settling reads back bits [9:0]. Everything resets to 0.
- R2: Writing 1 to bit 0 at offset 0x04 makes an internal pulse one cycle long. That offset always reads 0.
- R3: Width code 00 is 12-bit data. Right alignment takes holding bits [11:0]. Left alignment takes bits [15:4].
- R4: Width code 01 is 8-bit data. Right alignment takes holding bits [7:0]. Left alignment takes bits [15:8]. The byte is placed in output bits [11:4], and bits [3:0] are 0. Codes 10 and 11 behave as 12-bit data.
- R5: For a settling value S, status bit 8 (busy) is 1 for exactly S+1 cycles. These cycles begin with the cycle in which `conv_start` is high. Status bit 0 (finish) becomes 1 in the cycle after busy falls.
- R6: A new conversion start clears finish. Writing 1 to status bit 0 also clears it. Writing 0 to that bit leaves it unchanged.
- R7: In direct mode (control bit 4 = 0), a holding write starts a conversion if the block is enabled and not busy. `conv_start` is then high, and `conv_data` carries the new code, in the second cycle after the write edge. A holding write while busy does not start a conversion.
- R8: In trigger mode, a conversion starts on `trig_in`, or on the software pulse, while the block is enabled and not busy. A `trig_in` high at an edge produces `conv_start` in the next cycle. Holding writes do not start a conversion, and triggers that arrive while busy are dropped.
- R9: While control bit 0 is 0, no conversion starts.
- R10: In DMA mode, a conversion start with no holding write since the previous start sets status bit 1 (under-run). Writing 1 to status bit 1 clears it.
- R11: `irq` = (finish AND control bit 1) OR (under-run AND control bit 3).
- R12: `conv_data` reads back at offset 0x0C. Bus writes to that offset are ignored. `conv_data` changes only in a cycle in which `conv_start` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, combinational from the address |
| trig_in | input | 1 | Qualified conversion trigger |
| conv_data | output | 12 | Code presented to the analog core |
| conv_start | output | 1 | One-cycle conversion start strobe |
| irq | output | 1 | Masked interrupt request |

## Verification
Register writes land on the edge that closes the APB access phase. A holding write or software-trigger write shows up on `conv_start` and `conv_data` two edges later, and a `trig_in` pulse shows up one edge later. Busy then holds for S+1 cycles, and finish follows one edge after busy falls. The bench tracks these delays in a behavioural model that is stepped on every rising edge. It compares `conv_data`, `conv_start` and `irq` with the model on every falling edge. Register reads are sampled in the access cycle, after the falling edge, and checked against the model's current state.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    localparam int HOLD_W = 16;
    localparam int SMP_W  = 12;
    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;

    // word indices (byte address >> 2)
    localparam int IDX_CTL  = 0;
    localparam int IDX_SWT  = 1;
    localparam int IDX_HOLD = 2;
    localparam int IDX_OUT  = 3;
    localparam int IDX_STAT = 4;
    localparam int IDX_TIME = 5;

    typedef enum logic [1:0] {
        WID_12 = 2'b00,
        WID_8  = 2'b01,
        WID_X2 = 2'b10,
        WID_X3 = 2'b11
    } width_e;

    typedef struct packed {
        logic   run_en;
        logic   fin_ie;
        logic   dma_en;
        logic   udr_ie;
        logic   trig_mode;
        logic   left;
        width_e width;
    } ctl_t;

    function automatic ctl_t word_to_ctl(input logic [BUS_W-1:0] d);
        ctl_t c;
        c.run_en    = d[0];
        c.fin_ie    = d[1];
        c.dma_en    = d[2];
        c.udr_ie    = d[3];
        c.trig_mode = d[4];
        c.left      = d[10];
        c.width     = width_e'(d[15:14]);
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctl_to_word(input ctl_t c);
        logic [BUS_W-1:0] w;
        w        = '0;
        w[0]     = c.run_en;
        w[1]     = c.fin_ie;
        w[2]     = c.dma_en;
        w[3]     = c.udr_ie;
        w[4]     = c.trig_mode;
        w[10]    = c.left;
        w[15:14] = c.width;
        return w;
    endfunction

endpackage

// File: rtl/dac_seq_align.sv
module dac_seq_align
    import dac_seq_pkg::*;
(
    input  logic [HOLD_W-1:0] hold,
    input  ctl_t              ctl,
    output logic [SMP_W-1:0]  sample
);
    localparam int PAD_W = SMP_W - BYTE_W;

    logic [BYTE_W-1:0] byte_sel;
    logic [SMP_W-1:0]  wide_sel;

    always_comb begin
        byte_sel = ctl.left ? hold[HOLD_W-1 -: BYTE_W] : hold[BYTE_W-1:0];
        wide_sel = ctl.left ? hold[HOLD_W-1 -: SMP_W]  : hold[SMP_W-1:0];
        if (ctl.width == WID_8)
            sample = {byte_sel, {PAD_W{1'b0}}};
        else
            sample = wide_sel;
    end
endmodule

// File: rtl/dac_seq_regs.sv
module dac_seq_regs
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SETTLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [BUS_W-1:0]    pwdata,
    input  logic [SMP_W-1:0]    dout,
    input  logic                busy,
    input  logic                finish,
    input  logic                udr,
    output ctl_t                ctl,
    output logic [HOLD_W-1:0]   hold,
    output logic [SETTLE_W-1:0] settle,
    output logic                sw_pulse,
    output logic                data_wr,
    output logic                fin_clr,
    output logic                udr_clr,
    output logic [BUS_W-1:0]    prdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr;

    assign idx     = paddr[ADDR_W-1:2];
    assign wr      = psel && penable && pwrite;
    assign fin_clr = wr && (int'(idx) == IDX_STAT) && pwdata[0];
    assign udr_clr = wr && (int'(idx) == IDX_STAT) && pwdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            hold     <= '0;
            settle   <= '0;
            sw_pulse <= 1'b0;
            data_wr  <= 1'b0;
        end else begin
            sw_pulse <= wr && (int'(idx) == IDX_SWT) && pwdata[0];
            data_wr  <= wr && (int'(idx) == IDX_HOLD);
            if (wr && (int'(idx) == IDX_CTL))  ctl    <= word_to_ctl(pwdata);
            if (wr && (int'(idx) == IDX_HOLD)) hold   <= pwdata[HOLD_W-1:0];
            if (wr && (int'(idx) == IDX_TIME)) settle <= pwdata[SETTLE_W-1:0];
        end
    end

    always_comb begin
        prdata = '0;
        case (int'(idx))
            IDX_CTL:  prdata = ctl_to_word(ctl);
            IDX_HOLD: prdata = BUS_W'(hold);
            IDX_OUT:  prdata = BUS_W'(dout);
            IDX_STAT: prdata = BUS_W'({busy, 6'b0, udr, finish});
            IDX_TIME: prdata = BUS_W'(settle);
            default:  prdata = '0;
        endcase
    end
endmodule

// File: rtl/dac_seq_core.sv
module dac_seq_core
    import dac_seq_pkg::*;
#(
    parameter int SETTLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  ctl_t                ctl,
    input  logic [SETTLE_W-1:0] settle,
    input  logic [SMP_W-1:0]    sample,
    input  logic                sw_pulse,
    input  logic                data_wr,
    input  logic                trig_in,
    input  logic                fin_clr,
    input  logic                udr_clr,
    output logic [SMP_W-1:0]    dout,
    output logic                conv_start,
    output logic                busy,
    output logic                finish,
    output logic                udr,
    output logic                irq
);
    logic [SETTLE_W-1:0] count;
    logic                fresh;
    logic                trig_evt;
    logic                start;
    logic                stale;
    logic                done;

    assign trig_evt = ctl.trig_mode ? (trig_in || sw_pulse) : data_wr;
    assign start    = ctl.run_en && !busy && trig_evt;
    assign stale    = ctl.dma_en && !(fresh || data_wr);
    assign done     = busy && (count >= settle);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= '0;
            conv_start <= 1'b0;
            busy       <= 1'b0;
            count      <= '0;
            finish     <= 1'b0;
            udr        <= 1'b0;
            fresh      <= 1'b0;
        end else begin
            conv_start <= start;
            fresh      <= (fresh || data_wr) && !start;
            if (start) begin
                dout  <= sample;
                busy  <= 1'b1;
                count <= '0;
            end else if (done) begin
                busy  <= 1'b0;
            end else if (busy) begin
                count <= count + 1'b1;
            end
            if (start)        finish <= 1'b0;
            else if (done)    finish <= 1'b1;
            else if (fin_clr) finish <= 1'b0;
            if (start && stale) udr <= 1'b1;
            else if (udr_clr)   udr <= 1'b0;
        end
    end

    assign irq = (finish && ctl.fin_ie) || (udr && ctl.udr_ie);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy); // R5
    AST_DONE_RAISES_FINISH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> finish); // R5
    AST_BUSY_NOT_FINISHED: assert property (@(posedge clk) disable iff (rst)
        busy |-> !finish); // R6
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !conv_start |-> $stable(dout)); // R12
    AST_UDR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(udr) && !$past(udr_clr)) |-> udr); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (finish || udr)); // R11
endmodule

// File: rtl/dac_seq_top.sv
module dac_seq_top
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SETTLE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              trig_in,
    output logic [11:0]       conv_data,
    output logic              conv_start,
    output logic              irq
);
    ctl_t                ctl;
    logic [HOLD_W-1:0]   hold;
    logic [SETTLE_W-1:0] settle;
    logic [SMP_W-1:0]    sample;
    logic [SMP_W-1:0]    dout;
    logic                sw_pulse, data_wr, fin_clr, udr_clr;
    logic                busy, finish, udr;

    dac_seq_regs #(.ADDR_W(ADDR_W), .SETTLE_W(SETTLE_W)) u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .dout(dout), .busy(busy),
        .finish(finish), .udr(udr), .ctl(ctl), .hold(hold), .settle(settle),
        .sw_pulse(sw_pulse), .data_wr(data_wr), .fin_clr(fin_clr),
        .udr_clr(udr_clr), .prdata(prdata)
    );

    dac_seq_align u_align (
        .hold(hold), .ctl(ctl), .sample(sample)
    );

    dac_seq_core #(.SETTLE_W(SETTLE_W)) u_core (
        .clk(clk), .rst(rst), .ctl(ctl), .settle(settle), .sample(sample),
        .sw_pulse(sw_pulse), .data_wr(data_wr), .trig_in(trig_in),
        .fin_clr(fin_clr), .udr_clr(udr_clr), .dout(dout),
        .conv_start(conv_start), .busy(busy), .finish(finish), .udr(udr),
        .irq(irq)
    );

    assign conv_data = dout;
endmodule

// File: tb/test_dac_seq_top.sv
`timescale 1ns/1ps
module test_dac_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        trig_in = 1'b0;
    logic [11:0] conv_data;
    logic        conv_start;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    dac_seq_top i_dac_seq_top (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .trig_in(trig_in),
        .conv_data(conv_data), .conv_start(conv_start), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_ctl;
    logic [15:0] m_hold;
    logic [9:0]  m_settle;
    logic [11:0] m_dout;
    bit m_swp, m_wrp, m_busy, m_fin, m_udr, m_fresh, m_start;
    int m_rem;

    function automatic logic [11:0] model_sample(logic [31:0] c, logic [15:0] h);
        bit lft = c[10];
        if (c[15:14] == 2'b01) begin
            logic [7:0] b = lft ? h[15:8] : h[7:0];
            return {b, 4'h0};
        end
        return lft ? h[15:4] : h[11:0];
    endfunction

    always @(posedge clk) begin
        bit wr, st, stale, fclr, uclr;
        int idx;
        wr  = psel && penable && pwrite;
        idx = int'(paddr) / 4;
        if (rst) begin
            m_ctl = 0; m_hold = 0; m_settle = 0; m_dout = 0;
            m_swp = 0; m_wrp = 0; m_busy = 0; m_fin = 0; m_udr = 0;
            m_fresh = 0; m_start = 0; m_rem = 0;
        end else begin
            st    = m_ctl[0] && !m_busy && (m_ctl[4] ? (trig_in || m_swp) : m_wrp);
            stale = m_ctl[2] && !(m_fresh || m_wrp);
            fclr  = wr && idx == 4 && pwdata[0];
            uclr  = wr && idx == 4 && pwdata[1];
            m_start = st;
            if (st) begin
                m_fin = 0;
                if (stale) m_udr = 1; else if (uclr) m_udr = 0;
                m_dout = model_sample(m_ctl, m_hold);
                m_busy = 1; m_rem = int'(m_settle);
                m_fresh = 0;
            end else begin
                if (m_busy && m_rem == 0) begin m_busy = 0; m_fin = 1; end
                else begin
                    if (m_busy) m_rem--;
                    if (fclr) m_fin = 0;
                end
                if (uclr) m_udr = 0;
                m_fresh = m_fresh || m_wrp;
            end
            m_swp = wr && idx == 1 && pwdata[0];
            m_wrp = wr && idx == 2;
            if (wr && idx == 0) m_ctl = pwdata & 32'h0000_C41F;
            if (wr && idx == 2) m_hold = pwdata[15:0];
            if (wr && idx == 5) m_settle = pwdata[9:0];
        end
    end

    function automatic logic [31:0] model_read(int idx);
        case (idx)
            0: return m_ctl;
            2: return {16'h0, m_hold};
            3: return {20'h0, m_dout};
            4: return {23'h0, m_busy, 6'h0, m_udr, m_fin};
            5: return {22'h0, m_settle};
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_run) begin
            vectors++;
            if (conv_data !== m_dout) begin
                fails++;
                $display("FAIL R3 R4 R12 conv_data got %h exp %h at %0t", conv_data, m_dout, $time);
            end
            vectors++;
            if (conv_start !== m_start) begin
                fails++;
                $display("FAIL R7 R8 R9 conv_start got %b exp %b at %0t", conv_start, m_start, $time);
            end
            vectors++;
            if (irq !== ((m_fin && m_ctl[1]) || (m_udr && m_ctl[3]))) begin
                fails++;
                $display("FAIL R11 irq got %b exp %b at %0t", irq,
                         (m_fin && m_ctl[1]) || (m_udr && m_ctl[3]), $time);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1;
        e = model_read(int'(a) / 4);
        vectors++;
        if (prdata !== e) begin
            fails++;
            $display("FAIL %s read @%h got %h exp %h", tag, a, prdata, e);
        end
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_const(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1;
        vectors++;
        if (prdata !== e) begin
            fails++;
            $display("FAIL %s read @%h got %h exp %h", tag, a, prdata, e);
        end
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1;
        @(negedge clk); trig_in = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 0;
        // R1 reset state
        rd_const(8'h00, 32'h0, "R1 reset ctl");
        rd_const(8'h10, 32'h0, "R1 reset status");
        // R1 readback masks
        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_const(8'h00, 32'h0000_C41F, "R1 ctl mask");
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_const(8'h14, 32'h0000_03FF, "R1 settle mask");
        wr_reg(8'h14, 32'd3);
        wr_reg(8'h00, 32'h3);
        // R7 R3 direct-mode start, 12-bit right
        wr_reg(8'h08, 32'hFFFF_ABCD);
        rd_const(8'h08, 32'h0000_ABCD, "R1 hold mask");
        rd_chk(8'h10, "R5 status after start");
        idle(6);
        rd_chk(8'h10, "R5 finish set");
        rd_const(8'h0C, 32'h0000_0BCD, "R3 right 12-bit");
        // R6 write-0 keeps, write-1 clears
        wr_reg(8'h10, 32'h0);
        rd_const(8'h10, 32'h1, "R6 finish kept on write 0");
        wr_reg(8'h10, 32'h1);
        rd_const(8'h10, 32'h0, "R6 finish W1C");
        // R3 left 12-bit
        wr_reg(8'h00, 32'h403);
        wr_reg(8'h08, 32'hABCD);
        idle(8);
        rd_const(8'h0C, 32'h0000_0ABC, "R3 left 12-bit");
        // R4 8-bit modes
        wr_reg(8'h00, 32'h4003);
        wr_reg(8'h08, 32'h12EF);
        idle(8);
        rd_const(8'h0C, 32'h0000_0EF0, "R4 right 8-bit");
        wr_reg(8'h00, 32'h4403);
        wr_reg(8'h08, 32'h12EF);
        idle(8);
        rd_const(8'h0C, 32'h0000_0120, "R4 left 8-bit");
        wr_reg(8'h00, 32'h8003);
        wr_reg(8'h08, 32'h5678);
        idle(8);
        rd_const(8'h0C, 32'h0000_0678, "R4 reserved width as 12-bit");
        // R6 new start clears finish; R7 write while busy ignored
        wr_reg(8'h00, 32'h3);
        wr_reg(8'h14, 32'd20);
        wr_reg(8'h08, 32'h0111);
        wr_reg(8'h08, 32'h0222);
        rd_chk(8'h10, "R6 finish cleared by start");
        rd_const(8'h0C, 32'h0000_0111, "R7 write while busy");
        idle(25);
        rd_const(8'h0C, 32'h0000_0111, "R7 no late start");
        // R9 disabled, R12 output not writable
        wr_reg(8'h00, 32'h2);
        wr_reg(8'h14, 32'd2);
        wr_reg(8'h08, 32'h0333);
        idle(5);
        rd_const(8'h0C, 32'h0000_0111, "R9 no start when disabled");
        pulse_trig();
        wr_reg(8'h0C, 32'h0000_0FFF);
        rd_const(8'h0C, 32'h0000_0111, "R12 output write ignored");
        // R8 trigger mode
        wr_reg(8'h00, 32'h13);
        wr_reg(8'h08, 32'h0444);
        idle(4);
        rd_const(8'h0C, 32'h0000_0111, "R8 write no start in trigger mode");
        pulse_trig();
        idle(5);
        rd_const(8'h0C, 32'h0000_0444, "R8 trig_in start");
        wr_reg(8'h08, 32'h0555);
        wr_reg(8'h04, 32'h1);
        rd_const(8'h04, 32'h0, "R2 swtrig reads 0");
        idle(5);
        rd_const(8'h0C, 32'h0000_0555, "R2 swtrig start");
        wr_reg(8'h14, 32'd12);
        pulse_trig();
        wr_reg(8'h08, 32'h0666);
        pulse_trig();
        idle(2);
        rd_const(8'h0C, 32'h0000_0555, "R8 trigger while busy dropped");
        idle(15);
        // R10 DMA under-run
        wr_reg(8'h14, 32'd1);
        wr_reg(8'h00, 32'h1F);
        pulse_trig();
        idle(4);
        rd_chk(8'h10, "R10 fresh data no underrun");
        pulse_trig();
        idle(4);
        rd_const(8'h10, 32'h3, "R10 underrun set");
        wr_reg(8'h10, 32'h1);
        rd_const(8'h10, 32'h2, "R10 underrun kept");
        wr_reg(8'h10, 32'h2);
        rd_const(8'h10, 32'h0, "R10 underrun W1C");
        wr_reg(8'h08, 32'h0777);
        pulse_trig();
        idle(4);
        rd_chk(8'h10, "R10 no underrun after write");
        rd_const(8'h0C, 32'h0000_0777, "R8 DMA data");
        idle(3);
        summary();
    end
endmodule